// File: doc/BRIEF.md
# Prescaled Frame Reference Divider

This block derives a slow, periodic frame reference from a fast input clock and reports the settings a downstream fine-delay stage needs. The frame path has two stages. A power-of-two prescaler divides by 1, 2 or 4, and a programmable integer divider follows it. Odd main ratios are allowed. The output period is the product of the two ratios. Alongside this path, an independent power-of-two divider produces a one-cycle reference tick at the interpolator rate.

A step encoder turns a requested delay step (0 to 508) into a 2-bit quadrant code and a 7-bit fine code. The quadrants follow the sequence 0, 1, 3, 2. The fine code falls in the first and third segments and rises in the second and fourth, so adjacent steps always differ by a single fine count.

A registered error flag reports three conditions: an illegal prescaler code, a main ratio below two, and a frame period that is not a whole number of interpolator periods while both generator mode and the delay path are selected. A new configuration is adopted only at a frame boundary, or when the divider starts. An invalid configuration holds the frame output low.

Top module: `sysref_frame_gen`

## Requirements
- R1: `pre_sel` selects the prescale ratio P: 0 gives ÷1, 1 gives ÷2, 2 gives ÷4. Code 3 is illegal: `cfg_err` is raised and the frame output stays low.
- R2: While running with main ratio N (2 to 4095), `sysref_out` rises once every P·N clock cycles. The overall ratio therefore spans 2 to 16380.
- R3: In each frame, `sysref_out` is high for P·floor(N/2) clock cycles, starting at the rising edge. Even N gives a 50% duty cycle.
- R4: A main ratio of 0 or 1 is a configuration error. `cfg_err` is raised, the divider does not start, and `sysref_out` never rises while the error is flagged.
- R5: `interp_tick` is high for one clock cycle in every D cycles. `interp_sel` values 0, 1, 2, 3 give D = 2, 4, 8, 16. The tick runs whenever reset is low, independent of `en`.
- R6: When `gen_mode` and `dly_engage` are both 1 and P·N is not a multiple of D, `cfg_err` is raised and the frame output is held low. With either bit at 0, this check does not apply.
- R7: `cfg_err` is registered. It reflects the configuration inputs sampled at the previous rising clock edge.
- R8: A configuration change made while running takes effect at the next frame boundary. The frame in progress completes with its old period. If the new configuration is invalid, the divider stops at that boundary.
- R9: When `en` is sampled high with a valid configuration, `sysref_out` is high from the next cycle. When `en` is sampled low, `sysref_out` is low from the next cycle.
- R10: Step s maps as follows. For 0..127: quadrant 0, fine 127−s. For 128..254: quadrant 1, fine s−127. For 255..381: quadrant 3, fine 381−s. For 382..508: quadrant 2, fine s−381.
- R11: Step values above 508 encode as step 508 (quadrant 2, fine 127). The delay codes are registered, with one cycle of latency.
- R12: Synchronous active-high reset clears both dividers and the encoder. `sysref_out`, `cfg_err`, `dly_quad` and `dly_fine` read 0 while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable for the frame divider |
| pre_sel | input | 2 | Prescaler code (0: ÷1, 1: ÷2, 2: ÷4, 3: illegal) |
| main_ratio | input | 12 | Main divider ratio N |
| interp_sel | input | 2 | Interpolator tick ratio code (D = 2 << code) |
| gen_mode | input | 1 | Generator mode selected |
| dly_engage | input | 1 | Delay path selected |
| dly_step | input | 9 | Requested delay step number |
| sysref_out | output | 1 | Frame reference output |
| interp_tick | output | 1 | One-cycle tick at the interpolator rate |
| dly_quad | output | 2 | Encoded quadrant code |
| dly_fine | output | 7 | Encoded fine code |
| cfg_err | output | 1 | Configuration error flag |

## Verification
Outputs are sampled on the falling clock edge, after the state has settled.

- `cfg_err` and the delay codes are due at the first falling edge after the rising edge that samples the stimulus. The bench therefore checks them exactly one falling edge after driving the inputs.
- `sysref_out` rises at the first falling edge after `en` is sampled. Frame period and high time are not tied to a fixed latency: the bench counts falling edges between consecutive rising transitions of the output, so pipeline delay does not affect the measured values.
- For the boundary case, the bench changes the ratio one cycle into a frame. It expects the next rise after the old period and the following rise after the new one.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

    localparam int RATIO_W  = 12;
    localparam int STEP_W   = 9;
    localparam int FINE_W   = 7;
    localparam int SEG_LEN  = 127;
    localparam int STEP_TOP = 4 * SEG_LEN;
    localparam int ITICK_W  = 4;

    typedef enum logic [1:0] {
        PRE_DIV1 = 2'd0,
        PRE_DIV2 = 2'd1,
        PRE_DIV4 = 2'd2,
        PRE_BAD  = 2'd3
    } pre_code_e;

    typedef struct packed {
        logic [1:0]         pre_log2;
        logic [RATIO_W-1:0] ratio;
    } frame_cfg_t;

    typedef struct packed {
        logic [1:0]        quad;
        logic [FINE_W-1:0] fine;
    } dly_code_t;

    function automatic logic [1:0] pre_log2_of(input logic [1:0] code);
        return (code == PRE_BAD) ? 2'd0 : code;
    endfunction

    function automatic logic cfg_is_valid(
        input logic [1:0]         pcode,
        input logic [RATIO_W-1:0] ratio,
        input logic [1:0]         isel,
        input logic               gen,
        input logic               dly
    );
        logic [RATIO_W+1:0] total;
        logic [4:0]         dmask;
        logic               bad;
        total = {2'b00, ratio} << pre_log2_of(pcode);
        dmask = (5'd2 << isel) - 5'd1;
        bad   = (pcode == PRE_BAD) || (ratio < RATIO_W'(2));
        if (gen && dly && ((total[4:0] & dmask) != 5'd0))
            bad = 1'b1;
        return !bad;
    endfunction

endpackage

// File: rtl/sfg_prescaler.sv
module sfg_prescaler #(
    parameter int CNT_W = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] pre_log2,
    output logic       tick
);
    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] mask;

    assign mask = CNT_W'((3'd1 << pre_log2) - 3'd1);
    assign tick = run && ((pcnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run || restart)
            pcnt <= '0;
        else
            pcnt <= pcnt + CNT_W'(1);
    end
endmodule

// File: rtl/sfg_frame_div.sv
module sfg_frame_div
    import sfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       cfg_ok,
    input  frame_cfg_t cfg_in,
    output logic       frame_out
);
    frame_cfg_t         act;
    logic               running;
    logic [RATIO_W-1:0] cnt;
    logic               pre_tick;
    logic               last_cnt;
    logic               boundary;

    assign last_cnt = (cnt == act.ratio - RATIO_W'(1));
    assign boundary = running && en && pre_tick && last_cnt;

    sfg_prescaler #(.CNT_W(2)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .run      (running),
        .restart  (boundary),
        .pre_log2 (act.pre_log2),
        .tick     (pre_tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
            act     <= '0;
        end else if (!running) begin
            cnt <= '0;
            if (en && cfg_ok) begin
                running <= 1'b1;
                act     <= cfg_in;
            end
        end else if (!en) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (pre_tick) begin
            if (last_cnt) begin
                cnt <= '0;
                if (cfg_ok)
                    act <= cfg_in;
                else
                    running <= 1'b0;
            end else begin
                cnt <= cnt + RATIO_W'(1);
            end
        end
    end

    assign frame_out = running && (cnt < (act.ratio >> 1));
endmodule

// File: rtl/sfg_interp_div.sv
module sfg_interp_div #(
    parameter int CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [CNT_W-1:0] icnt;
    logic [CNT_W-1:0] mask;

    assign mask = CNT_W'((5'd2 << sel) - 5'd1);
    assign tick = ((icnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst)
            icnt <= '0;
        else
            icnt <= icnt + CNT_W'(1);
    end
endmodule

// File: rtl/sfg_step_enc.sv
module sfg_step_enc
    import sfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STEP_W-1:0] step,
    output dly_code_t         code
);
    logic [STEP_W-1:0] s;
    dly_code_t         nxt;

    always_comb begin
        s = (step > STEP_W'(STEP_TOP)) ? STEP_W'(STEP_TOP) : step;
        if (s <= STEP_W'(SEG_LEN)) begin
            nxt.quad = 2'd0;
            nxt.fine = FINE_W'(STEP_W'(SEG_LEN) - s);
        end else if (s <= STEP_W'(2 * SEG_LEN)) begin
            nxt.quad = 2'd1;
            nxt.fine = FINE_W'(s - STEP_W'(SEG_LEN));
        end else if (s <= STEP_W'(3 * SEG_LEN)) begin
            nxt.quad = 2'd3;
            nxt.fine = FINE_W'(STEP_W'(3 * SEG_LEN) - s);
        end else begin
            nxt.quad = 2'd2;
            nxt.fine = FINE_W'(s - STEP_W'(3 * SEG_LEN));
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            code <= '0;
        else
            code <= nxt;
    end
endmodule

// File: rtl/sysref_frame_gen.sv
module sysref_frame_gen
    import sfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [1:0]         pre_sel,
    input  logic [RATIO_W-1:0] main_ratio,
    input  logic [1:0]         interp_sel,
    input  logic               gen_mode,
    input  logic               dly_engage,
    input  logic [STEP_W-1:0]  dly_step,
    output logic               sysref_out,
    output logic               interp_tick,
    output logic [1:0]         dly_quad,
    output logic [FINE_W-1:0]  dly_fine,
    output logic               cfg_err
);
    frame_cfg_t cfg_req;
    logic       cfg_ok;
    dly_code_t  code;

    assign cfg_req.pre_log2 = pre_log2_of(pre_sel);
    assign cfg_req.ratio    = main_ratio;
    assign cfg_ok = cfg_is_valid(pre_sel, main_ratio, interp_sel, gen_mode, dly_engage);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_err <= 1'b0;
        else
            cfg_err <= !cfg_ok;
    end

    sfg_frame_div u_frame (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .cfg_ok    (cfg_ok),
        .cfg_in    (cfg_req),
        .frame_out (sysref_out)
    );

    sfg_interp_div #(.CNT_W(ITICK_W)) u_itick (
        .clk  (clk),
        .rst  (rst),
        .sel  (interp_sel),
        .tick (interp_tick)
    );

    sfg_step_enc u_enc (
        .clk  (clk),
        .rst  (rst),
        .step (dly_step),
        .code (code)
    );

    assign dly_quad = code.quad;
    assign dly_fine = code.fine;
endmodule

// File: rtl/sfg_checker.sv
module sfg_checker (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic [1:0] pre_sel,
    input logic [8:0] dly_step,
    input logic       sysref_out,
    input logic       interp_tick,
    input logic [1:0] dly_quad,
    input logic [6:0] dly_fine,
    input logic       cfg_err
);
    assert_bad_pre_R1: assert property (@(posedge clk) disable iff (rst)
        (pre_sel == 2'd3) |=> cfg_err);

    assert_rise_valid_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sysref_out) |-> !cfg_err);

    assert_tick_narrow_R5: assert property (@(posedge clk) disable iff (rst)
        interp_tick |=> !interp_tick);

    assert_idle_low_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> !sysref_out);

    assert_first_quad_R10: assert property (@(posedge clk) disable iff (rst)
        (dly_step <= 9'd127) |=> (dly_quad == 2'd0));

    assert_saturate_R11: assert property (@(posedge clk) disable iff (rst)
        (dly_step > 9'd508) |=> (dly_quad == 2'd2 && dly_fine == 7'd127));
endmodule

bind sysref_frame_gen sfg_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .pre_sel     (pre_sel),
    .dly_step    (dly_step),
    .sysref_out  (sysref_out),
    .interp_tick (interp_tick),
    .dly_quad    (dly_quad),
    .dly_fine    (dly_fine),
    .cfg_err     (cfg_err)
);

// File: tb/sim_sysref_frame_gen.sv
`timescale 1ns/1ps
module sim_sysref_frame_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [1:0]  pre_sel = 2'd0;
    logic [11:0] main_ratio = 12'd2;
    logic [1:0]  interp_sel = 2'd0;
    logic        gen_mode = 1'b0;
    logic        dly_engage = 1'b0;
    logic [8:0]  dly_step = 9'd0;
    logic        sysref_out;
    logic        interp_tick;
    logic [1:0]  dly_quad;
    logic [6:0]  dly_fine;
    logic        cfg_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sysref_frame_gen u0 (
        .clk(clk), .rst(rst), .en(en), .pre_sel(pre_sel), .main_ratio(main_ratio),
        .interp_sel(interp_sel), .gen_mode(gen_mode), .dly_engage(dly_engage),
        .dly_step(dly_step), .sysref_out(sysref_out), .interp_tick(interp_tick),
        .dly_quad(dly_quad), .dly_fine(dly_fine), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_quad(input int s);
        int q[4] = '{0, 1, 3, 2};
        int sc = (s > 508) ? 508 : s;
        int seg = (sc == 0) ? 0 : (sc - 1) / 127;
        return q[seg];
    endfunction

    function automatic int model_fine(input int s);
        int sc = (s > 508) ? 508 : s;
        int seg = (sc == 0) ? 0 : (sc - 1) / 127;
        int off = sc - 127 * seg;
        return (seg % 2 == 0) ? 127 - off : off;
    endfunction

    // waits for a 0->1 transition of sysref_out seen at falling edges
    task automatic wait_rise(output bit seen);
        bit prev = sysref_out;
        seen = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!prev && sysref_out) begin
                seen = 1'b1;
                break;
            end
            prev = sysref_out;
        end
    endtask

    // called right after a rise was seen; counts to the next rise
    task automatic measure(output int period, output int high);
        bit prev = 1'b1;
        period = 0;
        high = 1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            period++;
            if (!prev && sysref_out) break;
            if (sysref_out) high++;
            prev = sysref_out;
        end
    endtask

    task automatic setup(input int p, input int n, input int isel, input bit g, input bit d);
        @(negedge clk);
        en = 1'b0;
        pre_sel = 2'(p);
        main_ratio = 12'(n);
        interp_sel = 2'(isel);
        gen_mode = g;
        dly_engage = d;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_frame(input int p, input int n);
        bit seen;
        int per, hi;
        int pr = 1 << p;
        setup(p, n, 0, 1'b0, 1'b0);
        en = 1'b1;
        @(negedge clk);
        check(sysref_out == 1'b1, "R9 start high", int'(sysref_out), 1);
        measure(per, hi);
        check(per == pr * n, "R2 period", per, pr * n);
        check(hi == pr * (n / 2), "R3 high time", hi, pr * (n / 2));
        wait_rise(seen);
        measure(per, hi);
        check(per == pr * n, "R2 second period", per, pr * n);
    endtask

    task automatic hold_low(input int cycles, input string req);
        int highs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sysref_out) highs++;
        end
        check(highs == 0, req, highs, 0);
    endtask

    initial begin
        #(20ns * 190000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        bit seen;
        int per, hi, cnt, d;
        void'($urandom(32'd20240617));

        // R12 reset state
        repeat (4) @(negedge clk);
        check(sysref_out == 1'b0, "R12 reset sysref", int'(sysref_out), 0);
        check(cfg_err == 1'b0, "R12 reset err", int'(cfg_err), 0);
        check(dly_quad == 2'd0 && dly_fine == 7'd0, "R12 reset codes",
              int'({dly_quad, dly_fine}), 0);
        rst = 1'b0;

        // R1 R2 R3 directed ratios for each prescaler
        for (int p = 0; p < 3; p++) begin
            run_frame(p, 2);
            run_frame(p, 3);
            run_frame(p, 7);
            run_frame(p, 10);
        end
        // random sample
        for (int k = 0; k < 10; k++)
            run_frame(int'($urandom % 3), 2 + int'($urandom % 150));
        run_frame(2, 4095);

        // R1 illegal prescaler code, R7 latency
        setup(0, 8, 0, 1'b0, 1'b0);
        check(cfg_err == 1'b0, "R7 err before edge", int'(cfg_err), 0);
        pre_sel = 2'd3;
        en = 1'b1;
        @(negedge clk);
        check(cfg_err == 1'b1, "R1 R7 bad prescaler flagged", int'(cfg_err), 1);
        hold_low(40, "R1 output low on bad prescaler");

        // R4 ratio below two
        setup(0, 1, 0, 1'b0, 1'b0);
        en = 1'b1;
        @(negedge clk);
        check(cfg_err == 1'b1, "R4 ratio 1 flagged", int'(cfg_err), 1);
        hold_low(30, "R4 output low ratio 1");
        setup(1, 0, 0, 1'b0, 1'b0);
        en = 1'b1;
        @(negedge clk);
        check(cfg_err == 1'b1, "R4 ratio 0 flagged", int'(cfg_err), 1);
        hold_low(30, "R4 output low ratio 0");

        // R6 multiplicity: P*N=6, D=4
        setup(0, 6, 1, 1'b1, 1'b1);
        en = 1'b1;
        @(negedge clk);
        check(cfg_err == 1'b1, "R6 6 vs 4 flagged", int'(cfg_err), 1);
        hold_low(30, "R6 output low on mismatch");
        setup(0, 6, 1, 1'b0, 1'b1);
        check(cfg_err == 1'b0, "R6 generator off no error", int'(cfg_err), 0);
        setup(0, 6, 1, 1'b1, 1'b0);
        check(cfg_err == 1'b0, "R6 delay path off no error", int'(cfg_err), 0);
        setup(2, 3, 1, 1'b1, 1'b1);
        en = 1'b1;
        @(negedge clk);
        check(cfg_err == 1'b0, "R6 12 vs 4 accepted", int'(cfg_err), 0);
        measure(per, hi);
        check(per == 12, "R6 accepted period", per, 12);
        setup(1, 3, 3, 1'b1, 1'b1);
        check(cfg_err == 1'b1, "R6 6 vs 16 flagged", int'(cfg_err), 1);

        // R8 change inside a frame
        setup(0, 10, 0, 1'b0, 1'b0);
        en = 1'b1;
        @(negedge clk);
        main_ratio = 12'd4;
        cnt = 0;
        wait_rise(seen);
        measure(per, hi);
        check(per == 4, "R8 new period after boundary", per, 4);
        setup(0, 10, 0, 1'b0, 1'b0);
        en = 1'b1;
        @(negedge clk);
        main_ratio = 12'd4;
        measure(per, hi);
        check(per == 10, "R8 old period completes", per, 10);
        measure(per, hi);
        check(per == 4, "R8 next period uses new ratio", per, 4);
        // invalid at boundary stops the divider
        setup(0, 6, 0, 1'b0, 1'b0);
        en = 1'b1;
        @(negedge clk);
        main_ratio = 12'd1;
        repeat (6) @(negedge clk);
        hold_low(30, "R8 invalid at boundary stops");

        // R9 disable
        setup(0, 20, 0, 1'b0, 1'b0);
        en = 1'b1;
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(sysref_out == 1'b0, "R9 low after disable", int'(sysref_out), 0);

        // R5 interpolator tick
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            interp_sel = 2'(s);
            repeat (20) @(negedge clk);
            while (!interp_tick) @(negedge clk);
            cnt = 0;
            do begin
                @(negedge clk);
                cnt++;
            end while (!interp_tick && cnt < 100);
            d = 2 << s;
            check(cnt == d, "R5 tick period", cnt, d);
            @(negedge clk);
            check(interp_tick == 1'b0, "R5 tick width", int'(interp_tick), 0);
        end

        // R10 R11 encoder sweep
        for (int s = 0; s < 512; s++) begin
            @(negedge clk);
            dly_step = 9'(s);
            @(negedge clk);
            if (s > 508)
                check(dly_quad == 2'd2 && dly_fine == 7'd127, "R11 saturation",
                      int'({dly_quad, dly_fine}), 2 * 128 + 127);
            else
                check(int'(dly_quad) == model_quad(s) && int'(dly_fine) == model_fine(s),
                      "R10 step encode", int'({dly_quad, dly_fine}),
                      model_quad(s) * 128 + model_fine(s));
        end
        // R11 latency: output holds until the clock edge
        @(negedge clk);
        dly_step = 9'd200;
        #1;
        check(dly_quad == 2'd2, "R11 one cycle latency", int'(dly_quad), 2);
        @(negedge clk);
        check(dly_quad == 2'd1 && dly_fine == 7'd73, "R11 encoded after edge",
              int'({dly_quad, dly_fine}), 128 + 73);

        // R12 reset mid run
        setup(0, 8, 0, 1'b0, 1'b0);
        en = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(sysref_out == 1'b0, "R12 reset clears output", int'(sysref_out), 0);
        check(dly_quad == 2'd0 && dly_fine == 7'd0, "R12 reset clears codes",
              int'({dly_quad, dly_fine}), 0);
        rst = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule